// File: doc/BRIEF.md
# Serial Flash Command Status and Interrupt Logic

This block holds the status flags of a serial flash controller and derives its interrupt and DMA request lines from them. It records that a memory-mode command has been configured and that a directly issued command is in progress. It ends that command when chip-select goes high, and it raises an end-of-command interrupt when that happens. It also offers software a self-clearing abort request, which it forwards to the serial sequencer as a one-cycle pulse.

Software writes reach it as single-cycle strobes. One strobe marks a write of the command register, one a write of the memory-command register, and one a write of the status register together with its write data. The sequencer reports chip-select deassertion and readiness after an abort. The shifting engine itself lives elsewhere. The status byte is read back combinationally from the flag registers.

Top module: `flash_cmd_status`

## Requirements
- R1: After reset, `status_o`, `irq_o`, `dma_req_o` and `abort_pulse_o` are all 0.
- R2: A `mcmd_wr` strobe sets the memory-command-configured flag (status bit 0) one cycle later. The strobe is ignored while the abort flag is 1.
- R3: A `cmd_wr` strobe sets the command-active flag (status bit 1) one cycle later, and is ignored while the abort flag is 1. A `cs_deassert` pulse without `cmd_wr` clears the flag one cycle later.
- R4: A status write with data bit 4 set is an abort. One cycle later the abort flag (status bit 4) is 1, bits 0 and 1 are 0, and `abort_pulse_o` is 1 for exactly one cycle. The abort beats `cs_deassert` in the same cycle.
- R5: The abort flag stays 1 while `seq_ready` is 0. It clears one cycle after a cycle in which it is 1 and `seq_ready` is 1.
- R6: The interrupt-request flag (status bit 5) is set one cycle after `cs_deassert` arrives while bit 1 is 1 and no abort is written. `cs_deassert` while bit 1 is 0, and a bit 1 cleared by abort, leave it unchanged.
- R7: A status write with data bit 5 set clears the interrupt-request flag one cycle later. When that write coincides with the set event of R6, the flag ends up 1.
- R8: `irq_o` rises together with the interrupt-request flag only if `irq_en` was 1 in the cycle the command ended. It falls when that flag is cleared.
- R9: `dma_req_o` equals `data_rdy` AND `dma_en` AND status bit 1, in the same cycle.
- R10: Status write data bits 0 and 1 have no effect. Status bits 2, 3, 6 and 7 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Command register write strobe |
| mcmd_wr | input | 1 | Memory-command register write strobe |
| stat_wr | input | 1 | Status register write strobe |
| stat_wdata | input | 8 | Status write data (bit 4 abort, bit 5 interrupt clear) |
| cs_deassert | input | 1 | Chip-select deassert event from the sequencer |
| seq_ready | input | 1 | Sequencer ready for a new command |
| irq_en | input | 1 | Interrupt enable |
| dma_en | input | 1 | DMA request enable |
| data_rdy | input | 1 | Data available for transfer |
| status_o | output | 8 | Status byte |
| irq_o | output | 1 | Interrupt request line |
| dma_req_o | output | 1 | DMA request |
| abort_pulse_o | output | 1 | One-cycle abort to the sequencer |

## Verification
A vector sequence covers commands that end with the interrupt enabled and with it disabled. It also covers a chip-select pulse while no command is active and an interrupt clear that coincides with a new end event, which separates correct set-over-clear priority from the reverse. Abort cases are tried with the sequencer held busy and with an end event in the same cycle. They show whether writes are blocked while the abort is pending and whether an abort can leak into the interrupt flag. Directed tests then cover reset, the width of the abort pulse and each term of the DMA gate.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam int STAT_W   = 8;
  localparam int B_MINIT  = 0;
  localparam int B_ACTIVE = 1;
  localparam int B_ABORT  = 4;
  localparam int B_INTRQ  = 5;

  function automatic logic wr_one(input logic [STAT_W-1:0] data, input int pos);
    return data[pos];
  endfunction

  function automatic logic [STAT_W-1:0] pack_status(input logic minit, input logic active,
                                                    input logic abort, input logic intrq);
    logic [STAT_W-1:0] s;
    s = '0;
    s[B_MINIT]  = minit;
    s[B_ACTIVE] = active;
    s[B_ABORT]  = abort;
    s[B_INTRQ]  = intrq;
    return s;
  endfunction
endpackage

// File: rtl/fcs_abort_ctl.sv
module fcs_abort_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic abort_set,
  input  logic seq_ready,
  output logic abort_q,
  output logic abort_pulse
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      abort_q     <= 1'b0;
      abort_pulse <= 1'b0;
    end else begin
      abort_pulse <= abort_set;
      if (abort_set)      abort_q <= 1'b1;
      else if (seq_ready) abort_q <= 1'b0;
    end
  end

  // R4: abort request is visible and pulsed one cycle after the write
  p_abort_seen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    abort_set |=> (abort_q && abort_pulse));
  // R5: abort stays pending while the sequencer is busy
  p_abort_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_q && !seq_ready) |=> abort_q);
  // R5: abort self-clears once the sequencer is ready
  p_abort_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_q && seq_ready && !abort_set) |=> !abort_q);
endmodule

// File: rtl/fcs_cmd_track.sv
module fcs_cmd_track (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_wr,
  input  logic mcmd_wr,
  input  logic cs_deassert,
  input  logic abort_set,
  input  logic abort_q,
  output logic minit_q,
  output logic active_q,
  output logic end_evt
);
  logic wr_ok;
  assign wr_ok   = !abort_q && !abort_set;
  assign end_evt = active_q && cs_deassert && !abort_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      minit_q  <= 1'b0;
      active_q <= 1'b0;
    end else begin
      if (abort_set)            minit_q <= 1'b0;
      else if (mcmd_wr && wr_ok) minit_q <= 1'b1;

      if (abort_set)            active_q <= 1'b0;
      else if (cmd_wr && wr_ok) active_q <= 1'b1;
      else if (cs_deassert)     active_q <= 1'b0;
    end
  end

  // R2: memory-command write accepted only without pending abort
  p_minit_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mcmd_wr && !abort_q && !abort_set) |=> minit_q);
  p_minit_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_q && !minit_q) |=> !minit_q);
  // R3: command write starts, chip-select deassert ends
  p_active_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !abort_q && !abort_set) |=> active_q);
  p_active_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_deassert && !cmd_wr) |=> !active_q);
  // R4: abort clears both flags
  p_abort_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
    abort_set |=> (!minit_q && !active_q));
endmodule

// File: rtl/fcs_irq_ctl.sv
module fcs_irq_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic end_evt,
  input  logic irq_en,
  input  logic clr_req,
  output logic intrq_q,
  output logic line_q
);
  logic clr_eff;
  assign clr_eff = clr_req && !end_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      intrq_q <= 1'b0;
      line_q  <= 1'b0;
    end else begin
      if (end_evt)      intrq_q <= 1'b1;
      else if (clr_req) intrq_q <= 1'b0;

      if (end_evt && irq_en) line_q <= 1'b1;
      else if (clr_eff)      line_q <= 1'b0;
    end
  end

  // R6: end of command sets the request flag
  p_intrq_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    end_evt |=> intrq_q);
  // R7: clear without coincident set clears the flag
  p_intrq_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_eff |=> !intrq_q);
  // R8: the line never stands without the flag
  p_line_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    line_q |-> intrq_q);
  // R8: disabled interrupt does not raise the line
  p_line_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_q && !irq_en) |=> !line_q);
endmodule

// File: rtl/fcs_dma_gate.sv
module fcs_dma_gate (
  input  logic dma_en,
  input  logic active,
  input  logic data_rdy,
  output logic dma_req
);
  assign dma_req = dma_en && active && data_rdy;

  // R9: request only in command mode with enable set
  always_comb begin
    p_dma_gate_r9: assert (!dma_req || (dma_en && active));
  end
endmodule

// File: rtl/flash_cmd_status.sv
module flash_cmd_status
  import fcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic              mcmd_wr,
  input  logic              stat_wr,
  input  logic [STAT_W-1:0] stat_wdata,
  input  logic              cs_deassert,
  input  logic              seq_ready,
  input  logic              irq_en,
  input  logic              dma_en,
  input  logic              data_rdy,
  output logic [STAT_W-1:0] status_o,
  output logic              irq_o,
  output logic              dma_req_o,
  output logic              abort_pulse_o
);
  logic abort_set, intr_clr;
  logic abort_q, minit_q, active_q, intrq_q, end_evt;

  assign abort_set = stat_wr && wr_one(stat_wdata, B_ABORT);
  assign intr_clr  = stat_wr && wr_one(stat_wdata, B_INTRQ);

  fcs_abort_ctl u_abort (
    .clk(clk), .rst_n(rst_n), .abort_set(abort_set), .seq_ready(seq_ready),
    .abort_q(abort_q), .abort_pulse(abort_pulse_o)
  );

  fcs_cmd_track u_track (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .mcmd_wr(mcmd_wr),
    .cs_deassert(cs_deassert), .abort_set(abort_set), .abort_q(abort_q),
    .minit_q(minit_q), .active_q(active_q), .end_evt(end_evt)
  );

  fcs_irq_ctl u_irq (
    .clk(clk), .rst_n(rst_n), .end_evt(end_evt), .irq_en(irq_en),
    .clr_req(intr_clr), .intrq_q(intrq_q), .line_q(irq_o)
  );

  fcs_dma_gate u_dma (
    .dma_en(dma_en), .active(active_q), .data_rdy(data_rdy), .dma_req(dma_req_o)
  );

  assign status_o = pack_status(minit_q, active_q, abort_q, intrq_q);

  // R6: abort never produces an interrupt request
  p_no_abort_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_set && !intrq_q) |=> !intrq_q);
  // R10: unused status positions stay zero
  p_spare_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[3:2] == 2'b00) && (status_o[7:6] == 2'b00));
endmodule

// File: tb/flash_cmd_status_tb_top.sv
module flash_cmd_status_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_wr = 0, mcmd_wr = 0, stat_wr = 0, cs_deassert = 0;
  logic seq_ready = 1, irq_en = 0, dma_en = 0, data_rdy = 0;
  logic [7:0] stat_wdata = 8'h00;
  logic [7:0] status_o;
  logic irq_o, dma_req_o, abort_pulse_o;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  flash_cmd_status dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .mcmd_wr(mcmd_wr), .stat_wr(stat_wr),
    .stat_wdata(stat_wdata), .cs_deassert(cs_deassert), .seq_ready(seq_ready),
    .irq_en(irq_en), .dma_en(dma_en), .data_rdy(data_rdy), .status_o(status_o),
    .irq_o(irq_o), .dma_req_o(dma_req_o), .abort_pulse_o(abort_pulse_o)
  );

  typedef struct packed {
    logic cw; logic mw; logic sw; logic [7:0] wd;
    logic csd; logic rdy; logic ien;
    logic [7:0] st; logic irq;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,1'b0,8'h00,1'b0,1'b1,1'b0,8'h00,1'b0}, // idle
    '{1'b0,1'b1,1'b0,8'h00,1'b0,1'b1,1'b0,8'h01,1'b0}, // R2 mcmd write
    '{1'b1,1'b0,1'b0,8'h00,1'b0,1'b1,1'b0,8'h03,1'b0}, // R3 cmd write
    '{1'b0,1'b0,1'b0,8'h00,1'b1,1'b1,1'b1,8'h21,1'b1}, // R6 R8 end, enabled
    '{1'b0,1'b0,1'b1,8'h20,1'b0,1'b1,1'b0,8'h01,1'b0}, // R7 clear
    '{1'b1,1'b0,1'b0,8'h00,1'b0,1'b1,1'b0,8'h03,1'b0}, // R3
    '{1'b0,1'b0,1'b0,8'h00,1'b1,1'b1,1'b0,8'h21,1'b0}, // R8 end, disabled
    '{1'b0,1'b0,1'b1,8'h20,1'b1,1'b1,1'b1,8'h01,1'b0}, // R6 cs while idle, R7 clear
    '{1'b1,1'b0,1'b0,8'h00,1'b0,1'b1,1'b0,8'h03,1'b0}, // R3
    '{1'b0,1'b0,1'b1,8'h20,1'b1,1'b1,1'b1,8'h21,1'b1}, // R7 set wins
    '{1'b0,1'b0,1'b1,8'h03,1'b0,1'b1,1'b0,8'h21,1'b1}, // R10 bits 0,1 no effect
    '{1'b0,1'b0,1'b1,8'h20,1'b0,1'b1,1'b0,8'h01,1'b0}, // R7 R8 clear drops line
    '{1'b1,1'b0,1'b0,8'h00,1'b0,1'b1,1'b0,8'h03,1'b0}, // R3
    '{1'b0,1'b0,1'b1,8'h10,1'b0,1'b0,1'b0,8'h10,1'b0}, // R4 abort, busy
    '{1'b1,1'b1,1'b0,8'h00,1'b0,1'b0,1'b0,8'h10,1'b0}, // R2 R3 R5 writes blocked
    '{1'b0,1'b0,1'b0,8'h00,1'b1,1'b0,1'b1,8'h10,1'b0}, // R6 no irq after abort
    '{1'b0,1'b0,1'b0,8'h00,1'b0,1'b1,1'b0,8'h00,1'b0}, // R5 self-clear
    '{1'b1,1'b0,1'b0,8'h00,1'b0,1'b1,1'b0,8'h02,1'b0}, // R3
    '{1'b0,1'b0,1'b1,8'h10,1'b1,1'b1,1'b1,8'h10,1'b0}, // R4 abort beats cs end
    '{1'b0,1'b0,1'b0,8'h00,1'b0,1'b1,1'b0,8'h00,1'b0}  // R5
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic cw, input logic mw, input logic sw, input logic [7:0] wd,
                       input logic csd, input logic rdy, input logic ien);
    @(negedge clk);
    cmd_wr = cw; mcmd_wr = mw; stat_wr = sw; stat_wdata = wd;
    cs_deassert = csd; seq_ready = rdy; irq_en = ien;
    @(posedge clk);
    #1;
    cmd_wr = 0; mcmd_wr = 0; stat_wr = 0; stat_wdata = 8'h00; cs_deassert = 0;
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 status", status_o, 8'h00);
    check("R1 outputs", {5'b0, irq_o, dma_req_o, abort_pulse_o}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].cw, VECS[i].mw, VECS[i].sw, VECS[i].wd,
            VECS[i].csd, VECS[i].rdy, VECS[i].ien);
      check($sformatf("vector %0d status", i), status_o, VECS[i].st);
      check($sformatf("vector %0d irq R8", i), {7'b0, irq_o}, {7'b0, VECS[i].irq});
    end

    // R4: abort pulse lasts one cycle
    drive(1'b0, 1'b0, 1'b1, 8'h10, 1'b0, 1'b1, 1'b0);
    check("R4 pulse high", {7'b0, abort_pulse_o}, 8'h01);
    drive(1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
    check("R4 pulse low", {7'b0, abort_pulse_o}, 8'h00);
    check("R5 cleared", status_o, 8'h00);

    // R9: DMA gate terms
    drive(1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    dma_en = 1; data_rdy = 1; #1;
    check("R9 all set", {7'b0, dma_req_o}, 8'h01);
    dma_en = 0; #1;
    check("R9 dma_en low", {7'b0, dma_req_o}, 8'h00);
    dma_en = 1; data_rdy = 0; #1;
    check("R9 data_rdy low", {7'b0, dma_req_o}, 8'h00);
    data_rdy = 1;
    drive(1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0);
    #1;
    check("R9 inactive", {7'b0, dma_req_o}, 8'h00);
    dma_en = 0; data_rdy = 0;

    // R1: reset in the middle of activity
    drive(1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    rst_n = 1'b0; #1;
    check("R1 async reset", status_o, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule